// File: doc/BRIEF.md
# Real-Time Clock Seconds, Alarm and Interrupt Core

This core keeps a 32-bit count of seconds behind a small word-addressed register bus. A prescaler outside the core supplies a one-cycle pulse at each second boundary. On that pulse the count either advances by one or takes a value that software wrote earlier. A new time therefore never lands between two boundaries. Software can read the written value back while it waits, and can tell from the seconds status bit whether the load has happened yet.

An alarm comparator raises the alarm event when the count takes a value equal to the programmed alarm. That value may come from an increment or from a load. The seconds event and the alarm event each latch into a status bit. Software clears a status bit by writing one to it. Each event also has a mask bit, which is set through an enable word and cleared through a separate disable word. The level interrupt output is high while any unmasked status bit is set.

The core also holds a 21-bit calibration word and a control word. The control word keeps only its oscillator-enable bit and its battery-switch bit. A 16-bit tick counter counts clock cycles since the last second pulse. Writing the calibration word restarts the tick counter.

Loading of the time is handled by a two-state machine. `ST_RUN` means no load is waiting. `ST_PEND` means a written time is waiting for the next boundary. The machine has four transitions:
- A set-time write moves it from `ST_RUN` to `ST_PEND`.
- A second pulse without a write moves it from `ST_PEND` back to `ST_RUN` and loads the count.
- A write while in `ST_PEND` stays in `ST_PEND` and replaces the waiting value.
- A pulse while in `ST_RUN` stays in `ST_RUN` and increments the count.

A write and a pulse in the same cycle are handled as follows. The pulse acts on the state as it was before that cycle, and the new value becomes the one that waits.

Top module: `rtc_core`

Register words, by word address (the byte offset divided by four):

| Word | Access | Contents |
|------|--------|----------|
| 0 | write only | time to load at the next boundary |
| 1 | read only | the waiting or last written time |
| 2 | write only | calibration, bits 20:0 |
| 3 | read only | calibration |
| 4 | read only | current seconds count |
| 5 | read only | tick counter |
| 6 | read/write | alarm value |
| 8 | read, write one to clear | interrupt status |
| 9 | read only | mask (bits that are unmasked) |
| 10 | write only | enable (unmask) |
| 11 | write only | disable (mask) |
| 16 | read/write | control: oscillator enable in bit 24, battery switch in bit 31 |

In the interrupt words, bit 0 is the seconds event and bit 1 is the alarm event.

## Requirements
- R1: After reset, the seconds count, the waiting time, the alarm, calibration, control and status all read 0. The mask word reads 0, meaning every event is masked. The interrupt output is low.
- R2: Each second pulse with no load waiting adds one to the seconds count (word 4). The count wraps from 0xFFFFFFFF to 0.
- R3: A write to word 0 leaves word 4 unchanged until the next second pulse, after which word 4 holds the written value. Word 1 returns the last value written to word 0.
- R4: Status bit 0 sets on every second pulse. Status bit 1 sets when the seconds count takes a value equal to the alarm word (word 6).
- R5: Writing 1 to a status bit (word 8) clears it. Writing 0 leaves it unchanged.
- R6: Writing 1 to bit n of word 10 unmasks event n. Writing 1 to bit n of word 11 masks it. Zero bits in those writes have no effect. Word 9 reads the unmasked bits.
- R7: Status bits set even while masked. The interrupt output is high exactly when some status bit is set and unmasked.
- R8: When an event sets a status bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R9: Word 6 reads back the alarm as written. Word 3 reads back bits 20:0 of the last write to word 2. Word 16 reads back only bits 24 and 31 of what was written, with all other bits 0.
- R10: Word 5 counts clock cycles since the last second pulse. It returns 0 when read in the cycle right after a write to word 2, and it increases by one per cycle after that.
- R11: Two writes to word 0 before one boundary load only the later value. Word 1 shows the later value.
- R12: Reads of unmapped or write-only words return 0. Writes to read-only words change nothing.
- R13: Read data appears on the bus the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_rd | input | 1 | read strobe, one cycle per read |
| bus_addr | input | ADDR_W | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered on the read strobe |
| sec_pulse | input | 1 | one-cycle second-boundary pulse from the prescaler |
| irq | output | 1 | level interrupt: OR of the unmasked status bits |

## Verification
Directed sequences cover the following cases:
- A deferred load, read before and after its boundary, which separates a deferred load from an immediate one.
- Two writes before one boundary, which shows which of the two values is loaded.
- A load of 0xFFFFFFFF followed by a pulse, which exercises the wrap.
- An alarm hit reached by incrementing, with the event masked and then unmasked, which separates "status sets" from "interrupt fires".
- A clear that coincides with both a seconds event and an alarm event, which shows that the set wins.

Random traffic then mixes writes, reads and pulses at random positions. This includes set-time writes in the same cycle as a pulse and alarm values placed just ahead of the count. Every read and the interrupt level are compared in every cycle against a bench model built from the requirements. This catches errors in ordering and priority that the directed cases do not reach.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // word addresses (byte offset / 4)
    localparam int unsigned WA_SET_WR = 0;
    localparam int unsigned WA_SET_RD = 1;
    localparam int unsigned WA_CAL_WR = 2;
    localparam int unsigned WA_CAL_RD = 3;
    localparam int unsigned WA_NOW    = 4;
    localparam int unsigned WA_TICK   = 5;
    localparam int unsigned WA_ALARM  = 6;
    localparam int unsigned WA_STAT   = 8;
    localparam int unsigned WA_MASK   = 9;
    localparam int unsigned WA_EN     = 10;
    localparam int unsigned WA_DIS    = 11;
    localparam int unsigned WA_CTRL   = 16;

    localparam int unsigned IRQ_N   = 2;
    localparam int unsigned IRQ_SEC = 0;
    localparam int unsigned IRQ_ALM = 1;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } load_state_e;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_pkg::*;
#(
    parameter int TW = 32,
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_pulse,
    input  logic          load_wr,
    input  logic [TW-1:0] load_val,
    input  logic          tick_clr,
    input  logic [TW-1:0] alarm_val,
    output logic [TW-1:0] now_q,
    output logic [TW-1:0] pend_q,
    output logic [KW-1:0] tick_q,
    output logic          alarm_hit
);
    load_state_e   state_q, state_d;
    logic [TW-1:0] now_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state and datapath outputs
    always_comb begin
        state_d = state_q;
        now_d   = now_q;
        unique case (state_q)
            ST_RUN: begin
                if (sec_pulse) now_d = now_q + TW'(1);
                if (load_wr)   state_d = ST_PEND;
            end
            ST_PEND: begin
                if (sec_pulse) now_d = pend_q;
                if (load_wr)        state_d = ST_PEND;
                else if (sec_pulse) state_d = ST_RUN;
            end
        endcase
        alarm_hit = sec_pulse && (now_d == alarm_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q  <= '0;
            pend_q <= '0;
            tick_q <= '0;
        end else begin
            now_q <= now_d;
            if (load_wr) pend_q <= load_val;
            if (sec_pulse || tick_clr) tick_q <= '0;
            else                       tick_q <= tick_q + KW'(1);
        end
    end

    p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && state_q == ST_RUN) |=> (now_q == $past(now_q) + TW'(1)));
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && state_q == ST_PEND) |=> (now_q == $past(pend_q)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_pulse |=> $stable(now_q));
    p_latest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (state_q == ST_PEND && pend_q == $past(load_val)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] status_q,
    output logic [N-1:0] unmask_q,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
                unmask_q[i] <= 1'b0;
            end else begin
                if (evt[i])                    status_q[i] <= 1'b1;
                else if (clr_wr && wbits[i])   status_q[i] <= 1'b0;
                if (en_wr && wbits[i])         unmask_q[i] <= 1'b1;
                else if (dis_wr && wbits[i])   unmask_q[i] <= 1'b0;
            end
        end

        p_setwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> status_q[i]);
        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && wbits[i] && !evt[i]) |=> !status_q[i]);
        p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_wr && wbits[i]) |=> unmask_q[i]);
        p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (dis_wr && wbits[i]) |=> !unmask_q[i]);
    end

    assign irq = |(status_q & unmask_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int TIME_W  = 32,
    parameter int TICK_W  = 16,
    parameter int CAL_W   = 21,
    parameter int OSC_BIT = 24,
    parameter int BAT_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sec_pulse,
    output logic              irq
);
    localparam int DW = 32;

    logic [TIME_W-1:0] now_q, pend_q, alarm_q;
    logic [TICK_W-1:0] tick_q;
    logic [CAL_W-1:0]  cal_q;
    logic              osc_q, bat_q;
    logic [IRQ_N-1:0]  status_q, unmask_q, evt;
    logic              alarm_hit;
    logic [DW-1:0]     rd_mux;

    logic sel_set, sel_cal, sel_alarm, sel_stat, sel_en, sel_dis, sel_ctrl;
    assign sel_set   = bus_wr && (bus_addr == ADDR_W'(WA_SET_WR));
    assign sel_cal   = bus_wr && (bus_addr == ADDR_W'(WA_CAL_WR));
    assign sel_alarm = bus_wr && (bus_addr == ADDR_W'(WA_ALARM));
    assign sel_stat  = bus_wr && (bus_addr == ADDR_W'(WA_STAT));
    assign sel_en    = bus_wr && (bus_addr == ADDR_W'(WA_EN));
    assign sel_dis   = bus_wr && (bus_addr == ADDR_W'(WA_DIS));
    assign sel_ctrl  = bus_wr && (bus_addr == ADDR_W'(WA_CTRL));

    rtc_sec_counter #(.TW(TIME_W), .KW(TICK_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .load_wr   (sel_set),
        .load_val  (bus_wdata[TIME_W-1:0]),
        .tick_clr  (sel_cal),
        .alarm_val (alarm_q),
        .now_q     (now_q),
        .pend_q    (pend_q),
        .tick_q    (tick_q),
        .alarm_hit (alarm_hit)
    );

    always_comb begin
        evt          = '0;
        evt[IRQ_SEC] = sec_pulse;
        evt[IRQ_ALM] = alarm_hit;
    end

    rtc_irq_ctrl #(.N(IRQ_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_wr   (sel_stat),
        .en_wr    (sel_en),
        .dis_wr   (sel_dis),
        .wbits    (bus_wdata[IRQ_N-1:0]),
        .status_q (status_q),
        .unmask_q (unmask_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            cal_q   <= '0;
            osc_q   <= 1'b0;
            bat_q   <= 1'b0;
        end else begin
            if (sel_alarm) alarm_q <= bus_wdata[TIME_W-1:0];
            if (sel_cal)   cal_q   <= bus_wdata[CAL_W-1:0];
            if (sel_ctrl) begin
                osc_q <= bus_wdata[OSC_BIT];
                bat_q <= bus_wdata[BAT_BIT];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(WA_SET_RD): rd_mux = DW'(pend_q);
            ADDR_W'(WA_CAL_RD): rd_mux = DW'(cal_q);
            ADDR_W'(WA_NOW):    rd_mux = DW'(now_q);
            ADDR_W'(WA_TICK):   rd_mux = DW'(tick_q);
            ADDR_W'(WA_ALARM):  rd_mux = DW'(alarm_q);
            ADDR_W'(WA_STAT):   rd_mux = DW'(status_q);
            ADDR_W'(WA_MASK):   rd_mux = DW'(unmask_q);
            ADDR_W'(WA_CTRL): begin
                rd_mux[OSC_BIT] = osc_q;
                rd_mux[BAT_BIT] = bat_q;
            end
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    p_rdhold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    p_alarmkeep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_alarm |=> $stable(alarm_q));
endmodule

// File: tb/rtc_core_test.sv
module rtc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, sec_pulse = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    rtc_core uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_pulse(sec_pulse), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic [31:0] m_now, m_pend, m_alarm, m_cal, m_ctrl, m_rdata;
    logic        m_pend_on;
    logic [15:0] m_tick;
    logic [1:0]  m_stat, m_en;

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            5'd1:  return m_pend;
            5'd3:  return m_cal;
            5'd4:  return m_now;
            5'd5:  return {16'h0, m_tick};
            5'd6:  return m_alarm;
            5'd8:  return {30'h0, m_stat};
            5'd9:  return {30'h0, m_en};
            5'd16: return m_ctrl;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] nxt;
        logic [1:0]  ev, clr;
        if (!rst_n) begin
            m_now = 0; m_pend = 0; m_alarm = 0; m_cal = 0; m_ctrl = 0;
            m_rdata = 0; m_pend_on = 0; m_tick = 0; m_stat = 0; m_en = 0;
        end else begin
            if (bus_rd) m_rdata = model_read(bus_addr);
            nxt = m_now;
            ev = 2'b00;
            if (sec_pulse) begin
                nxt = m_pend_on ? m_pend : m_now + 32'd1;
                ev[0] = 1'b1;
                ev[1] = (nxt == m_alarm);
            end
            clr = (bus_wr && bus_addr == 5'd8) ? bus_wdata[1:0] : 2'b00;
            m_stat = (m_stat & ~clr) | ev;
            if (bus_wr && bus_addr == 5'd10) m_en = m_en | bus_wdata[1:0];
            if (bus_wr && bus_addr == 5'd11) m_en = m_en & ~bus_wdata[1:0];
            if (sec_pulse || (bus_wr && bus_addr == 5'd2)) m_tick = 0;
            else m_tick = m_tick + 16'd1;
            if (bus_wr && bus_addr == 5'd0) begin
                m_pend = bus_wdata; m_pend_on = 1'b1;
            end else if (sec_pulse) m_pend_on = 1'b0;
            m_now = nxt;
            if (bus_wr && bus_addr == 5'd6)  m_alarm = bus_wdata;
            if (bus_wr && bus_addr == 5'd2)  m_cal = bus_wdata & 32'h001F_FFFF;
            if (bus_wr && bus_addr == 5'd16) m_ctrl = bus_wdata & 32'h8100_0000;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs change at the falling edge
    task automatic cyc(input logic w, input logic r, input logic [4:0] a,
                       input logic [31:0] d, input logic p);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; sec_pulse = p;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; sec_pulse = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic pulse();
        cyc(1'b0, 1'b0, 5'd0, 32'h0, 1'b1);
    endtask

    task automatic rdc(input logic [4:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 32'h0, 1'b0);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", WDOG);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rdc(5'd4, 32'h0, "R1 now");
        rdc(5'd8, 32'h0, "R1 status");
        rdc(5'd9, 32'h0, "R1 mask");
        rdc(5'd1, 32'h0, "R1 set readback");
        rdc(5'd16, 32'h0, "R1 control");

        // R9 readbacks, R10 tick restart
        wr(5'd6, 32'h0000_1234);
        rdc(5'd6, 32'h0000_1234, "R9 alarm");
        wr(5'd16, 32'hFFFF_FFFF);
        rdc(5'd16, 32'h8100_0000, "R9 control bits");
        wr(5'd2, 32'hFFFF_FFFF);
        rdc(5'd5, 32'h0, "R10 tick after calibration write");
        rdc(5'd5, 32'h1, "R10 tick increments");
        rdc(5'd3, 32'h001F_FFFF, "R9 calibration");

        // R3 deferred load
        wr(5'd0, 32'd100);
        rdc(5'd4, 32'h0, "R3 not loaded yet");
        rdc(5'd1, 32'd100, "R3 set readback");
        pulse();
        rdc(5'd4, 32'd100, "R3 loaded at boundary");
        rdc(5'd8, 32'h1, "R4 seconds status");

        // R2 increment, R11 later write wins
        pulse();
        rdc(5'd4, 32'd101, "R2 increment");
        wr(5'd0, 32'd50);
        wr(5'd0, 32'd60);
        rdc(5'd1, 32'd60, "R11 readback latest");
        rdc(5'd4, 32'd101, "R11 still pending");
        pulse();
        rdc(5'd4, 32'd60, "R11 later value loaded");

        // R2 wrap
        wr(5'd0, 32'hFFFF_FFFF);
        pulse();
        rdc(5'd4, 32'hFFFF_FFFF, "R2 load max");
        pulse();
        rdc(5'd4, 32'h0, "R2 wrap to zero");

        // R5 clear all
        wr(5'd8, 32'h3);
        rdc(5'd8, 32'h0, "R5 write one clears");

        // R4 alarm, R6 masks, R7 interrupt
        wr(5'd6, 32'd5);
        wr(5'd0, 32'd4);
        pulse();
        pulse();
        rdc(5'd8, 32'h3, "R4 alarm status");
        chk("R7 masked no irq", {31'h0, irq}, 32'h0);
        wr(5'd10, 32'h2);
        chk("R7 irq on unmask", {31'h0, irq}, 32'h1);
        rdc(5'd9, 32'h2, "R6 mask reads unmasked");
        wr(5'd8, 32'h0);
        rdc(5'd8, 32'h3, "R5 zero write no effect");
        wr(5'd8, 32'h2);
        chk("R7 irq drops after clear", {31'h0, irq}, 32'h0);
        rdc(5'd8, 32'h1, "R5 single bit cleared");
        wr(5'd10, 32'h1);
        chk("R7 seconds irq", {31'h0, irq}, 32'h1);
        wr(5'd11, 32'h1);
        chk("R6 disable masks", {31'h0, irq}, 32'h0);
        rdc(5'd9, 32'h2, "R6 disable only bit 0");
        wr(5'd11, 32'h2);
        rdc(5'd9, 32'h0, "R6 all masked");

        // R8 set wins over clear
        wr(5'd6, 32'd7);
        pulse();
        cyc(1'b1, 1'b0, 5'd8, 32'h3, 1'b1);
        rdc(5'd8, 32'h3, "R8 set wins");
        rdc(5'd4, 32'd7, "R8 count at alarm");

        // R12 unmapped, write-only, read-only
        rdc(5'd7, 32'h0, "R12 unmapped read");
        rdc(5'd0, 32'h0, "R12 write-only read");
        wr(5'd4, 32'd123);
        rdc(5'd4, 32'd7, "R12 now not writable");
        wr(5'd9, 32'h3);
        rdc(5'd9, 32'h0, "R12 mask not writable");

        // R13 read data held
        wr(5'd6, 32'hABCD);
        rdc(5'd6, 32'hABCD, "R13 read");
        pulse();
        chk("R13 rdata holds", bus_rdata, 32'hABCD);

        // random traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [4:0] a;
            logic [31:0] d;
            logic p;
            logic [4:0] alist [13] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
                                        5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd16};
            kind = int'($urandom_range(0, 2));
            a = alist[$urandom_range(0, 12)];
            p = ($urandom_range(0, 7) == 0);
            d = $urandom();
            if (a == 5'd6) d = m_now + 32'($urandom_range(0, 3));
            if (a == 5'd0 && $urandom_range(0, 1) == 1)
                d = 32'hFFFF_FFFF - 32'($urandom_range(0, 2));
            cyc(kind == 1, kind == 2, a, d, p);
            if (kind == 2) chk("R13 random read", bus_rdata, m_rdata);
            chk("R7 random irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
        end

        done = 1;
        summary();
        $finish;
    end
endmodule